// File: doc/BRIEF.md
# External Word-Clock Rate Meter

This block measures the rate of an external digital-audio word clock by counting cycles of a fixed reference clock between rising edges. It then maps the result onto the closest standard sample rate. Two candidate inputs exist. The host picks one with a select write, which restarts the count. Once enough periods have elapsed, a save write freezes the count into a pair of byte-wide output fields. The rate derived from the frozen count is reported only while the chosen input signals both clock presence and data presence.

The measured rate is the reference frequency (28,224,000 Hz by default) divided by the tick count, with the remainder discarded. That quotient is compared against a ladder of fifteen thresholds, and each comparison is a strict greater-than. Receiving the external stream and decoding its channel status are handled elsewhere.

Top module: `ext_rate_meter`

## Requirements
- R1: While reset is asserted, and after it is released until the first save, ticks_hi_o, ticks_lo_o and rate_hz_o are all zero.
- R2: A select write is a host_we_i cycle with host_save_i low and host_sel_i nonzero. It picks input 1 when host_sel_i[1] is set, even if bit 0 is also set, and picks input 0 when only host_sel_i[0] is set. It also discards the count in progress. A write with host_save_i low and host_sel_i equal to zero is ignored.
- R3: The live count is the number of reference cycles between two consecutive rising edges of the selected input, taken after a two-flop synchronizer. It reads zero until the second rising edge after a select write.
- R4: The live count saturates at 1023 and does not wrap.
- R5: A save write (host_we_i with host_save_i high) copies the live count and the current selection into the saved result, and host_sel_i is ignored during that write. From the next cycle on, ticks_lo_o carries count bits 7:0 and ticks_hi_o carries bits 9:8 in its bits 1:0, with its bits 7:2 at zero.
- R6: The reported rate is zero unless the saved input has both clock_present_i and data_present_i set. Bit 0 of each port belongs to input 0 and bit 1 to input 1.
- R7: Let q = floor(28224000 / count). Going from the highest threshold down, the first test that passes sets the rate: q>184200 gives 192000, q>152200 gives 176400, q>112000 gives 128000, q>92100 gives 96000, q>76100 gives 88200, q>56000 gives 64000, q>46050 gives 48000, q>38050 gives 44100, q>28000 gives 32000, q>23025 gives 24000, q>19025 gives 22050, q>14000 gives 16000, q>11512 gives 12000, q>9512 gives 11025, q>7000 gives 8000. If no test passes, or the count is zero, the rate is 0. rate_hz_o is registered and follows the saved count or the presence bits one cycle later.
- R8: Edges on the input that is not selected have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 2 | External word clocks, one per input |
| clock_present_i | input | 2 | Receiver reports clock present, per input |
| data_present_i | input | 2 | Receiver reports data present, per input |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 2 | Input select bits of a write |
| host_save_i | input | 1 | Write is a save rather than a select |
| ticks_hi_o | output | 8 | Saved count, upper bits in bits 1:0 |
| ticks_lo_o | output | 8 | Saved count, lower 8 bits |
| rate_hz_o | output | 18 | Rounded standard sample rate in Hz |

## Verification
Several properties are checked by assertions on every cycle. A select write clears the live count. The first rising edge after a select arms the counter without producing a count. A saturated counter stays at its limit. A save reproduces the previous live count. A missing presence bit or a zero count forces the rate to zero on the next cycle. Other behaviour can only be confirmed by the bench's scenarios: that the count equals the true edge spacing, that bit 1 wins the select, that an empty select is ignored, and that the ladder lands on the right rung at exact threshold values. For these, a behavioural model is compared with the outputs every cycle, and the expected rates are written out as numbers.

// File: rtl/ext_rate_meter_pkg.sv
package ext_rate_meter_pkg;

  localparam int unsigned LADDER_N = 15;

  // rung i passes when quotient > rung_floor(i); ascending, highest passing rung wins
  function automatic logic [31:0] rung_floor(input int unsigned idx);
    case (idx)
      0:  return 32'd7000;
      1:  return 32'd9512;
      2:  return 32'd11512;
      3:  return 32'd14000;
      4:  return 32'd19025;
      5:  return 32'd23025;
      6:  return 32'd28000;
      7:  return 32'd38050;
      8:  return 32'd46050;
      9:  return 32'd56000;
      10: return 32'd76100;
      11: return 32'd92100;
      12: return 32'd112000;
      13: return 32'd152200;
      14: return 32'd184200;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] rung_rate(input int unsigned idx);
    case (idx)
      0:  return 32'd8000;
      1:  return 32'd11025;
      2:  return 32'd12000;
      3:  return 32'd16000;
      4:  return 32'd22050;
      5:  return 32'd24000;
      6:  return 32'd32000;
      7:  return 32'd44100;
      8:  return 32'd48000;
      9:  return 32'd64000;
      10: return 32'd88200;
      11: return 32'd96000;
      12: return 32'd128000;
      13: return 32'd176400;
      14: return 32'd192000;
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/clk_edge_sync.sv
module clk_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] period_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_q, live_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      live_q  <= '0;
      armed_q <= 1'b0;
    end else if (restart_i) begin
      run_q   <= '0;
      live_q  <= '0;
      armed_q <= 1'b0;
    end else if (edge_i) begin
      if (armed_q) live_q <= run_q;
      run_q   <= CNT_W'(1);
      armed_q <= 1'b1;
    end else if (run_q != CNT_MAX) begin
      run_q <= run_q + CNT_W'(1);
    end
  end

  assign period_o = live_q;

  assert_restart_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (period_o == '0));

  assert_first_edge_arms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !restart_i && !armed_q) |=> (period_o == $past(period_o)));

  assert_sat_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == CNT_MAX && !restart_i && !edge_i) |=> (run_q == CNT_MAX));
endmodule

// File: rtl/rate_ladder.sv
module rate_ladder
  import ext_rate_meter_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned RATE_W = 18,
  parameter int unsigned REF_HZ = 28224000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  ticks_i,
  input  logic              enable_i,
  output logic [RATE_W-1:0] rate_o
);
  localparam int unsigned PW = 48;

  logic [RATE_W-1:0] cand;

  // floor(REF/t) > T  <=>  REF >= (T+1)*t : no divider needed
  always_comb begin
    cand = '0;
    if (ticks_i != '0) begin
      for (int i = 0; i < LADDER_N; i++) begin
        if (PW'(REF_HZ) >= PW'(rung_floor(i) + 32'd1) * PW'(ticks_i))
          cand = RATE_W'(rung_rate(i));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rate_o <= '0;
    else         rate_o <= enable_i ? cand : '0;
  end

  assert_zero_ticks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ticks_i == '0) |=> (rate_o == '0));
endmodule

// File: rtl/ext_rate_meter.sv
module ext_rate_meter #(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned RATE_W      = 18,
  parameter int unsigned REF_HZ      = 28224000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        ext_clk_i,
  input  logic [1:0]        clock_present_i,
  input  logic [1:0]        data_present_i,
  input  logic              host_we_i,
  input  logic [1:0]        host_sel_i,
  input  logic              host_save_i,
  output logic [7:0]        ticks_hi_o,
  output logic [7:0]        ticks_lo_o,
  output logic [RATE_W-1:0] rate_hz_o
);
  localparam int unsigned N_IN = 2;
  localparam int unsigned HI_W = CNT_W - 8;

  logic [N_IN-1:0]  rise;
  logic             sel_q, saved_sel_q;
  logic [CNT_W-1:0] live, saved_q;
  logic             sel_write, save_write, present_ok;

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    clk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (ext_clk_i[g]),
      .rise_o  (rise[g])
    );
  end

  assign sel_write  = host_we_i & ~host_save_i & (|host_sel_i);
  assign save_write = host_we_i & host_save_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_q <= 1'b0;
    else if (sel_write) sel_q <= host_sel_i[1];
  end

  period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (sel_write),
    .edge_i    (rise[sel_q]),
    .period_o  (live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saved_q     <= '0;
      saved_sel_q <= 1'b0;
    end else if (save_write) begin
      saved_q     <= live;
      saved_sel_q <= sel_q;
    end
  end

  assign present_ok = clock_present_i[saved_sel_q] & data_present_i[saved_sel_q];

  rate_ladder #(.CNT_W(CNT_W), .RATE_W(RATE_W), .REF_HZ(REF_HZ)) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ticks_i  (saved_q),
    .enable_i (present_ok),
    .rate_o   (rate_hz_o)
  );

  assign ticks_lo_o = saved_q[7:0];
  assign ticks_hi_o = 8'(saved_q[CNT_W-1:8]);

  assert_save_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_write |=> ({ticks_hi_o[HI_W-1:0], ticks_lo_o} == $past(live)));

  assert_absent_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_ok |=> (rate_hz_o == '0));
endmodule

// File: tb/tb_ext_rate_meter.sv
module tb_ext_rate_meter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext = 2'b00;
  logic [1:0] cp = 2'b11, dp = 2'b11;
  logic       we = 1'b0, save = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [7:0] t_hi, t_lo;
  logic [17:0] rate;

  int checks = 0, failures = 0;
  bit done = 0;
  int half [2];
  int hcnt [2];

  // behavioural reference state
  int m_s1 [2], m_s2 [2], m_pv [2];
  int m_sel, m_run, m_armed, m_live, m_saved, m_ssel, m_rate;

  always #10 clk = ~clk;

  ext_rate_meter dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext),
    .clock_present_i(cp), .data_present_i(dp),
    .host_we_i(we), .host_sel_i(sel), .host_save_i(save),
    .ticks_hi_o(t_hi), .ticks_lo_o(t_lo), .rate_hz_o(rate)
  );

  function automatic int std_rate(int t);
    int q;
    if (t == 0) return 0;
    q = 28224000 / t;
    if (q > 184200) return 192000;
    else if (q > 152200) return 176400;
    else if (q > 112000) return 128000;
    else if (q > 92100) return 96000;
    else if (q > 76100) return 88200;
    else if (q > 56000) return 64000;
    else if (q > 46050) return 48000;
    else if (q > 38050) return 44100;
    else if (q > 28000) return 32000;
    else if (q > 23025) return 24000;
    else if (q > 19025) return 22050;
    else if (q > 14000) return 16000;
    else if (q > 11512) return 12000;
    else if (q > 9512) return 11025;
    else if (q > 7000) return 8000;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // external clock generators
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (half[k] != 0) begin
        hcnt[k]++;
        if (hcnt[k] >= half[k]) begin
          ext[k] <= ~ext[k];
          hcnt[k] = 0;
        end
      end
    end
  end

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin m_s1[k] = 0; m_s2[k] = 0; m_pv[k] = 0; end
      m_sel = 0; m_run = 0; m_armed = 0; m_live = 0; m_saved = 0; m_ssel = 0; m_rate = 0;
    end else begin
      int rise_m, nrate;
      rise_m = (m_s2[m_sel] == 1 && m_pv[m_sel] == 0) ? 1 : 0;
      nrate = (cp[m_ssel] && dp[m_ssel]) ? std_rate(m_saved) : 0;
      if (we && save) begin m_saved = m_live; m_ssel = m_sel; end
      if (we && !save && sel != 2'b00) begin
        m_sel = sel[1] ? 1 : 0; m_run = 0; m_armed = 0; m_live = 0;
      end else if (rise_m == 1) begin
        if (m_armed == 1) m_live = m_run;
        m_run = 1; m_armed = 1;
      end else if (m_run < 1023) m_run++;
      m_rate = nrate;
      for (int k = 0; k < 2; k++) begin m_pv[k] = m_s2[k]; m_s2[k] = m_s1[k]; m_s1[k] = int'(ext[k]); end
    end
  end

  // per-cycle comparison against model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 ticks_hi", int'(t_hi), m_saved >> 8);
      check("R5 ticks_lo", int'(t_lo), m_saved & 255);
      check("R7 rate", int'(rate), m_rate);
    end
  end

  task automatic host_wr(logic [1:0] s, logic sv);
    @(negedge clk); we = 1'b1; sel = s; save = sv;
    @(negedge clk); we = 1'b0; sel = 2'b00; save = 1'b0;
  endtask

  task automatic settle(int p);
    repeat (3 * p + 8) @(negedge clk);
  endtask

  task automatic save_and_check(string req, int exp_ticks, int exp_rate);
    host_wr(2'b00, 1'b1);
    check({req, " ticks"}, {22'd0, t_hi[1:0], t_lo}, exp_ticks);
    check({req, " hi_upper_zero"}, int'(t_hi[7:2]), 0);
    @(negedge clk);
    check({req, " rate"}, int'(rate), exp_rate);
  endtask

  initial begin
    half[0] = 294; half[1] = 7; hcnt[0] = 0; hcnt[1] = 0;
    @(negedge clk);
    check("R1 reset ticks_lo", int'(t_lo), 0);
    check("R1 reset rate", int'(rate), 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset hi", int'(t_hi), 0);
    check("R1 after reset rate", int'(rate), 0);

    // input 0 at 588 cycles while input 1 runs fast (R8)
    host_wr(2'b01, 1'b0);
    settle(588);
    save_and_check("R3 R8 input0", 588, 48000);

    // empty select write ignored (R2)
    host_wr(2'b00, 1'b0);
    save_and_check("R2 empty select", 588, 48000);

    // both bits: input 1 wins (R2)
    host_wr(2'b11, 1'b0);
    settle(14);
    save_and_check("R2 bit1 priority", 14, 192000);

    // presence gating (R6)
    @(negedge clk); dp[1] = 1'b0;
    @(negedge clk);
    check("R6 data absent", int'(rate), 0);
    dp[1] = 1'b1; cp[1] = 1'b0;
    @(negedge clk);
    check("R6 clock absent", int'(rate), 0);
    cp[1] = 1'b1;
    @(negedge clk);
    check("R6 restored", int'(rate), 192000);

    // ladder points (R7)
    half[1] = 252; host_wr(2'b10, 1'b0); settle(504);
    save_and_check("R7 exact 56000 boundary", 504, 48000);
    half[1] = 80; host_wr(2'b10, 1'b0); settle(160);
    save_and_check("R7 176400", 160, 176400);
    half[1] = 441; host_wr(2'b10, 1'b0); settle(882);
    save_and_check("R7 32000", 882, 32000);
    half[1] = 320; host_wr(2'b10, 1'b0); settle(640);
    save_and_check("R7 44100", 640, 44100);

    // saturation (R4)
    half[1] = 600; host_wr(2'b10, 1'b0); settle(1200);
    save_and_check("R4 saturate", 1023, 24000);

    // save before two edges (R3)
    host_wr(2'b01, 1'b0);
    save_and_check("R3 early save", 0, 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule